// File: doc/BRIEF.md
# Interrupt Source Presented/Queued State Buffer

This block keeps a two-bit event state for each of a set of interrupt sources. One bit, P, records that a notification for the source has been presented to the router and not yet retired. The other bit, Q, records that a further trigger arrived while P was held. Repeat triggers therefore coalesce into one outstanding notification plus one remembered event, instead of flooding the router.

Software reaches the state through a load/store request channel. Each request names a source and an offset. The offset picks the operation: read the state, force the state to a given value while returning the old one, or end-of-interrupt. Edge sources take pulses on `trig_in` and retire through an end-of-interrupt that replays a remembered Q. Level sources sample `lvl_in` and fire again on end-of-interrupt while the line is still high. A compatibility mode folds each offset into itself shifted left by four before decode. Notifications leave on a valid/ready channel that carries the source index.

Top module: `isrc_pq_engine`

## Requirements
- R1: After reset every source holds state 01 (masked), `rsp_valid` and `notify_valid` are low, and a read of any source returns 01.
- R2: A load whose effective offset has bits 9:8 equal to 00 or 11 returns the source state in `rsp_data` bits 1:0 (P in bit 1, Q in bit 0, upper bits zero) and leaves the state unchanged.
- R3: A load whose effective offset has bits 9:8 equal to 10 writes the state to offset bits 5:4 (bit 5 to P, bit 4 to Q) and returns the state from before the write.
- R4: A trigger moves state 00 to 10 and raises one notification for the source. It moves 10 to 11 and leaves 11 as it is, with no notification in either case. It has no effect in state 01.
- R5: On an edge source, a load with offset bits 9:8 equal to 01 (end-of-interrupt) returns the old state and clears it to 00. If the old Q was 1, the source is triggered again at once, ending in 10 with a notification. Forcing 11 and then ending the interrupt therefore replays the source.
- R6: A level source triggers on a rising edge of its `lvl_in` bit and ignores `trig_in`. Its end-of-interrupt clears the state to 00 and triggers again when `lvl_in` is high in that cycle. Q is not used for this decision.
- R7: A store with offset bits 9:8 equal to 01 has the same effect on state and notifications as the end-of-interrupt load but produces no response. Stores with any other operation are ignored.
- R8: When `errata_en` is high, the offset used for decode is `req_ofs | (req_ofs << 4)`, truncated to the offset width.
- R9: Each source has at most one notification outstanding. `notify_valid` is high while any is outstanding. The lowest-numbered outstanding source is offered first. Once offered, `notify_src` holds until `notify_ready` is seen.
- R10: A request is accepted when `req_valid` and `req_ready` are both high. `req_ready` is low only while a response is held with `rsp_ready` low. An accepted load shows its response on the next cycle, and the response holds stable until `rsp_ready` is seen.
- R11: When a request and a trigger hit the same source in one cycle, the request is applied first and the trigger is applied to the resulting state. The returned value is the state from before both.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| errata_en | input | 1 | Enables the offset fold before decode |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be taken |
| req_store | input | 1 | 1 = store, 0 = load |
| req_src | input | SRC_W (3) | Source index |
| req_ofs | input | OFS_W (12) | Access offset |
| rsp_valid | output | 1 | Load response present |
| rsp_ready | input | 1 | Response consumer ready |
| rsp_data | output | DATA_W (8) | Returned state, P in bit 1, Q in bit 0 |
| trig_in | input | NUM_SRC (8) | One-cycle trigger pulses for edge sources |
| lvl_in | input | NUM_SRC (8) | Input lines for level sources |
| notify_valid | output | 1 | Notification offered |
| notify_ready | input | 1 | Router takes the notification |
| notify_src | output | SRC_W (3) | Source of the offered notification |

## Verification
A load accepted at one rising edge has its response, with the pre-access state, on the outputs right after that edge. The state change and any notification it causes become visible at that same edge, so a read issued on the next cycle already sees the new state. A trigger or level rise behaves the same way: the state moves and `notify_valid` rises right after the edge that samples it. The bench drives every input just after a falling edge and compares all outputs 1 ns later against a cycle model, so each expected value is sampled exactly one edge after its stimulus.

// File: rtl/isrc_pkg.sv
`timescale 1ns/1ps
package isrc_pkg;

  typedef logic [1:0] pq_t;

  localparam pq_t PQ_IDLE = 2'b00;
  localparam pq_t PQ_MASK = 2'b01;
  localparam pq_t PQ_PRES = 2'b10;
  localparam pq_t PQ_BOTH = 2'b11;

  typedef enum logic [1:0] {
    OP_GET   = 2'b00,
    OP_EOI   = 2'b01,
    OP_SETPQ = 2'b10,
    OP_PEEK  = 2'b11
  } isrc_op_e;

  typedef struct packed {
    pq_t  pq;
    logic notify;
  } trig_res_t;

  // One trigger event applied to a state value.
  function automatic trig_res_t trig_apply(input pq_t cur);
    trig_res_t r;
    r.pq     = cur;
    r.notify = 1'b0;
    case (cur)
      PQ_IDLE: begin
        r.pq     = PQ_PRES;
        r.notify = 1'b1;
      end
      PQ_PRES: r.pq = PQ_BOTH;
      default: ;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/isrc_offset_decode.sv
`timescale 1ns/1ps
module isrc_offset_decode
  import isrc_pkg::*;
#(
  parameter int OFS_W   = 12,
  parameter int OP_LSB  = 8,
  parameter int VAL_LSB = 4
) (
  input  logic [OFS_W-1:0] ofs,
  input  logic             errata_en,
  output isrc_op_e         op,
  output pq_t              set_val
);

  localparam int FOLD_SH = 4;

  logic [OFS_W-1:0] eff;

  always_comb begin
    eff     = errata_en ? (ofs | (ofs << FOLD_SH)) : ofs;
    op      = isrc_op_e'(eff[OP_LSB +: 2]);
    set_val = eff[VAL_LSB +: 2];
  end

endmodule

// File: rtl/isrc_source_cell.sv
`timescale 1ns/1ps
module isrc_source_cell
  import isrc_pkg::*;
#(
  parameter bit IS_LEVEL = 1'b0
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     acc_hit,
  input  logic     acc_store,
  input  isrc_op_e acc_op,
  input  pq_t      set_val,
  input  logic     trig_in,
  input  logic     lvl_in,
  output pq_t      pq_q,
  output logic     notify_evt,
  output logic     trig_evt
);

  logic      lvl_prev_q;
  logic      rearm;
  pq_t       pq_acc;
  trig_res_t r_eoi;
  trig_res_t r_trg;

  always_comb begin
    trig_evt = IS_LEVEL ? (lvl_in & ~lvl_prev_q) : trig_in;

    // access step first
    pq_acc = pq_q;
    rearm  = 1'b0;
    if (acc_hit) begin
      case (acc_op)
        OP_SETPQ: if (!acc_store) pq_acc = set_val;
        OP_EOI: begin
          pq_acc = PQ_IDLE;
          rearm  = IS_LEVEL ? lvl_in : pq_q[0];
        end
        default: ;
      endcase
    end

    // replay caused by the end-of-interrupt
    if (rearm) r_eoi = trig_apply(pq_acc);
    else       r_eoi = '{pq: pq_acc, notify: 1'b0};

    // external trigger lands on the post-access state
    if (trig_evt) r_trg = trig_apply(r_eoi.pq);
    else          r_trg = '{pq: r_eoi.pq, notify: 1'b0};

    notify_evt = r_eoi.notify | r_trg.notify;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pq_q       <= PQ_MASK;
      lvl_prev_q <= 1'b0;
    end else begin
      pq_q       <= r_trg.pq;
      lvl_prev_q <= lvl_in;
    end
  end

endmodule

// File: rtl/isrc_notify_arb.sv
`timescale 1ns/1ps
module isrc_notify_arb #(
  parameter int NUM_SRC = 8,
  parameter int SRC_W   = $clog2(NUM_SRC)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] raise,
  input  logic               notify_ready,
  output logic               notify_valid,
  output logic [SRC_W-1:0]   notify_src
);

  logic [NUM_SRC-1:0] pend_q;
  logic [NUM_SRC-1:0] clr;
  logic [SRC_W-1:0]   pick;
  logic [SRC_W-1:0]   lock_src_q;
  logic               lock_q;
  logic               take;

  always_comb begin
    pick = '0;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (pend_q[i]) pick = SRC_W'(i);
    end
  end

  assign notify_valid = |pend_q;
  assign notify_src   = lock_q ? lock_src_q : pick;
  assign take         = notify_valid && notify_ready;
  assign clr          = take ? (NUM_SRC'(1) << notify_src) : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q     <= '0;
      lock_q     <= 1'b0;
      lock_src_q <= '0;
    end else begin
      pend_q     <= (pend_q & ~clr) | raise;
      lock_q     <= notify_valid && !notify_ready;
      lock_src_q <= notify_src;
    end
  end

endmodule

// File: rtl/isrc_pq_engine.sv
`timescale 1ns/1ps
module isrc_pq_engine
  import isrc_pkg::*;
#(
  parameter int                 NUM_SRC    = 8,
  parameter int                 OFS_W      = 12,
  parameter int                 DATA_W     = 8,
  parameter int                 SRC_W      = $clog2(NUM_SRC),
  parameter logic [NUM_SRC-1:0] LEVEL_MASK =
    {{(NUM_SRC/2){1'b1}}, {(NUM_SRC - NUM_SRC/2){1'b0}}}
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               errata_en,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic               req_store,
  input  logic [SRC_W-1:0]   req_src,
  input  logic [OFS_W-1:0]   req_ofs,
  output logic               rsp_valid,
  input  logic               rsp_ready,
  output logic [DATA_W-1:0]  rsp_data,
  input  logic [NUM_SRC-1:0] trig_in,
  input  logic [NUM_SRC-1:0] lvl_in,
  output logic               notify_valid,
  input  logic               notify_ready,
  output logic [SRC_W-1:0]   notify_src
);

  localparam int PAD_W = DATA_W - 2;

  isrc_op_e                 dec_op;
  pq_t                      dec_val;
  logic                     fire;
  logic [NUM_SRC-1:0]       acc_hit;
  logic [NUM_SRC-1:0]       raise;
  logic [NUM_SRC-1:0]       trig_seen;
  logic [NUM_SRC-1:0][1:0]  pq_all;
  pq_t                      rd_pq;
  pq_t                      rsp_pq_q;
  logic                     rsp_valid_q;

  assign req_ready = !rsp_valid_q || rsp_ready;
  assign fire      = req_valid && req_ready;

  isrc_offset_decode #(.OFS_W(OFS_W)) dec_i (
    .ofs       (req_ofs),
    .errata_en (errata_en),
    .op        (dec_op),
    .set_val   (dec_val)
  );

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
    assign acc_hit[g] = fire && (req_src == SRC_W'(g));

    isrc_source_cell #(.IS_LEVEL(LEVEL_MASK[g])) cell_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .acc_hit    (acc_hit[g]),
      .acc_store  (req_store),
      .acc_op     (dec_op),
      .set_val    (dec_val),
      .trig_in    (trig_in[g]),
      .lvl_in     (lvl_in[g]),
      .pq_q       (pq_all[g]),
      .notify_evt (raise[g]),
      .trig_evt   (trig_seen[g])
    );
  end

  // old state of the addressed source, returned by loads
  always_comb begin
    rd_pq = PQ_IDLE;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (req_src == SRC_W'(i)) rd_pq = pq_all[i];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid_q <= 1'b0;
      rsp_pq_q    <= PQ_IDLE;
    end else if (fire && !req_store) begin
      rsp_valid_q <= 1'b1;
      rsp_pq_q    <= rd_pq;
    end else if (rsp_ready) begin
      rsp_valid_q <= 1'b0;
    end
  end

  assign rsp_valid = rsp_valid_q;
  assign rsp_data  = {{PAD_W{1'b0}}, rsp_pq_q};

  isrc_notify_arb #(.NUM_SRC(NUM_SRC), .SRC_W(SRC_W)) arb_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .raise        (raise),
    .notify_ready (notify_ready),
    .notify_valid (notify_valid),
    .notify_src   (notify_src)
  );

endmodule

// File: rtl/isrc_pq_engine_chk.sv
`timescale 1ns/1ps
module isrc_pq_engine_chk #(
  parameter int NUM_SRC = 8,
  parameter int DATA_W  = 8,
  parameter int SRC_W   = 3
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     req_valid,
  input logic                     req_ready,
  input logic                     req_store,
  input logic                     rsp_valid,
  input logic                     rsp_ready,
  input logic [DATA_W-1:0]        rsp_data,
  input logic                     notify_valid,
  input logic                     notify_ready,
  input logic [SRC_W-1:0]         notify_src,
  input logic [1:0]               dec_op,
  input logic [NUM_SRC-1:0]       acc_hit,
  input logic [NUM_SRC-1:0]       trig_seen,
  input logic [NUM_SRC-1:0][1:0]  pq_all
);

  // R10
  rsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_data));

  // R10
  load_answer_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready && !req_store |=> rsp_valid);

  // R9
  notify_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    notify_valid && !notify_ready |=> notify_valid && $stable(notify_src));

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_chk
    // R4
    both_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pq_all[g] == 2'b11 && !acc_hit[g] |=> pq_all[g] == 2'b11);

    // R2
    read_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      acc_hit[g] && (dec_op == 2'b00 || dec_op == 2'b11) && !trig_seen[g]
      |=> pq_all[g] == $past(pq_all[g]));
  end

endmodule

bind isrc_pq_engine isrc_pq_engine_chk #(
  .NUM_SRC (NUM_SRC),
  .DATA_W  (DATA_W),
  .SRC_W   (SRC_W)
) chk_i (
  .clk          (clk),
  .rst_n        (rst_n),
  .req_valid    (req_valid),
  .req_ready    (req_ready),
  .req_store    (req_store),
  .rsp_valid    (rsp_valid),
  .rsp_ready    (rsp_ready),
  .rsp_data     (rsp_data),
  .notify_valid (notify_valid),
  .notify_ready (notify_ready),
  .notify_src   (notify_src),
  .dec_op       (dec_op),
  .acc_hit      (acc_hit),
  .trig_seen    (trig_seen),
  .pq_all       (pq_all)
);

// File: tb/isrc_pq_engine_tb_top.sv
`timescale 1ns/1ps
module isrc_pq_engine_tb_top;

  localparam int           N   = 8;
  localparam int           OW  = 12;
  localparam int           DW  = 8;
  localparam int           SW  = 3;
  localparam logic [N-1:0] LVL = 8'hF0;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          errata_en = 1'b0;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic          req_store = 1'b0;
  logic [SW-1:0] req_src = '0;
  logic [OW-1:0] req_ofs = '0;
  logic          rsp_valid;
  logic          rsp_ready = 1'b1;
  logic [DW-1:0] rsp_data;
  logic [N-1:0]  trig_in = '0;
  logic [N-1:0]  lvl_in = '0;
  logic          notify_valid;
  logic          notify_ready = 1'b1;
  logic [SW-1:0] notify_src;

  isrc_pq_engine #(.NUM_SRC(N), .OFS_W(OW), .DATA_W(DW), .LEVEL_MASK(LVL)) dut_i (
    .clk(clk), .rst_n(rst_n), .errata_en(errata_en),
    .req_valid(req_valid), .req_ready(req_ready), .req_store(req_store),
    .req_src(req_src), .req_ofs(req_ofs),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data),
    .trig_in(trig_in), .lvl_in(lvl_in),
    .notify_valid(notify_valid), .notify_ready(notify_ready), .notify_src(notify_src)
  );

  always #2.5 clk = ~clk;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  // cycle model
  logic [1:0]    m_pq [N];
  logic [N-1:0]  m_pend;
  logic [N-1:0]  m_lvlp;
  logic          m_rsp_v;
  logic [1:0]    m_rsp_d;
  logic          m_lock;
  logic [SW-1:0] m_lock_src;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [OW-1:0] fold(input logic [OW-1:0] o, input logic e);
    return e ? (o | (o << 4)) : o;
  endfunction

  function automatic logic [SW-1:0] lowest(input logic [N-1:0] v);
    logic [SW-1:0] r = '0;
    for (int i = N - 1; i >= 0; i--) if (v[i]) r = SW'(i);
    return r;
  endfunction

  // compare outputs with the model, then advance model and clock one cycle
  task automatic step();
    logic          exp_rr, fire, nv, hs;
    logic [SW-1:0] sel;
    logic [OW-1:0] eo;
    logic [1:0]    op, val, old;
    #1;
    exp_rr = !m_rsp_v || rsp_ready;
    nv     = |m_pend;
    sel    = m_lock ? m_lock_src : lowest(m_pend);
    chk(req_ready === exp_rr, "R10 req_ready", req_ready, exp_rr);
    chk(rsp_valid === m_rsp_v, "R10 rsp_valid", rsp_valid, m_rsp_v);
    if (m_rsp_v) chk(rsp_data === {6'b0, m_rsp_d}, "R2 R3 R5 rsp_data", rsp_data, m_rsp_d);
    chk(notify_valid === nv, "R9 notify_valid", notify_valid, nv);
    if (nv) chk(notify_src === sel, "R9 notify_src", notify_src, sel);
    fire = req_valid && exp_rr;
    hs   = nv && notify_ready;
    eo   = fold(req_ofs, errata_en);
    op   = eo[9:8];
    val  = eo[5:4];
    old  = m_pq[req_src];
    for (int s = 0; s < N; s++) begin
      logic [1:0] st;
      logic nt, tg, rt;
      st = m_pq[s]; nt = 1'b0; rt = 1'b0;
      if (fire && req_src == SW'(s)) begin
        if (op == 2'b10 && !req_store) st = val;
        else if (op == 2'b01) begin
          st = 2'b00;
          rt = LVL[s] ? lvl_in[s] : m_pq[s][0];
        end
      end
      if (rt) begin st = 2'b10; nt = 1'b1; end
      tg = LVL[s] ? (lvl_in[s] && !m_lvlp[s]) : trig_in[s];
      if (tg) begin
        if (st == 2'b00) begin st = 2'b10; nt = 1'b1; end
        else if (st == 2'b10) st = 2'b11;
      end
      m_pq[s] = st;
      if (hs && sel == SW'(s)) m_pend[s] = 1'b0;
      if (nt) m_pend[s] = 1'b1;
      m_lvlp[s] = lvl_in[s];
    end
    m_lock     = nv && !notify_ready;
    m_lock_src = sel;
    if (fire && !req_store) begin m_rsp_v = 1'b1; m_rsp_d = old; end
    else if (rsp_ready) m_rsp_v = 1'b0;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic access(input logic st, input int src, input logic [OW-1:0] ofs);
    req_valid = 1'b1; req_store = st; req_src = SW'(src); req_ofs = ofs;
    step();
    req_valid = 1'b0; req_store = 1'b0;
  endtask

  task automatic pulse(input int src);
    trig_in[src] = 1'b1;
    step();
    trig_in = '0;
  endtask

  task automatic exp_rsp(input string tag, input logic [1:0] e);
    chk(rsp_valid === 1'b1 && rsp_data === {6'b0, e}, tag, rsp_data, e);
  endtask

  task automatic exp_note(input string tag, input logic v, input int src);
    chk(notify_valid === v && (!v || notify_src === SW'(src)), tag, {notify_valid, notify_src}, {v, SW'(src)});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    for (int s = 0; s < N; s++) begin m_pq[s] = 2'b01; end
    m_pend = '0; m_lvlp = '0; m_rsp_v = 1'b0; m_rsp_d = '0; m_lock = 1'b0; m_lock_src = '0;
    void'($urandom(32'd5171));
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1 reset state
    chk(rsp_valid === 1'b0, "R1 rsp_valid after reset", rsp_valid, 0);
    chk(notify_valid === 1'b0, "R1 notify_valid after reset", notify_valid, 0);
    for (int s = 0; s < N; s++) begin
      access(1'b0, s, 12'h000);
      exp_rsp("R1 reset state", 2'b01);
    end

    // R4 masked source ignores triggers
    pulse(0);
    exp_note("R4 masked no notify", 1'b0, 0);
    access(1'b0, 0, 12'h300);
    exp_rsp("R4 masked stays 01 (R2 alt read)", 2'b01);

    // R3 set, then R4 trigger ladder
    access(1'b0, 0, 12'h200);
    exp_rsp("R3 set returns old", 2'b01);
    pulse(0);
    exp_note("R4 00 to 10 notifies", 1'b1, 0);
    pulse(0);
    exp_note("R4 10 to 11 silent", 1'b0, 0);
    pulse(0);
    access(1'b0, 0, 12'h000);
    exp_rsp("R4 11 sticky", 2'b11);

    // R5 edge end-of-interrupt with Q set
    access(1'b0, 0, 12'h100);
    exp_rsp("R5 eoi returns old", 2'b11);
    exp_note("R5 replay notify", 1'b1, 0);
    access(1'b0, 0, 12'h000);
    exp_rsp("R5 replay state", 2'b10);
    access(1'b0, 0, 12'h100);
    exp_note("R5 no replay when Q clear", 1'b0, 0);
    access(1'b0, 0, 12'h000);
    exp_rsp("R5 cleared", 2'b00);

    // R5 forced 11 then eoi replays
    access(1'b0, 2, 12'h230);
    exp_rsp("R3 set 11 returns old", 2'b01);
    access(1'b0, 2, 12'h100);
    exp_rsp("R5 retrigger eoi old", 2'b11);
    exp_note("R5 retrigger notify", 1'b1, 2);
    access(1'b0, 2, 12'h000);
    exp_rsp("R5 retrigger state", 2'b10);

    // R7 store eoi
    access(1'b0, 2, 12'h230);
    access(1'b1, 2, 12'h100);
    chk(rsp_valid === 1'b0, "R7 store no response", rsp_valid, 0);
    exp_note("R7 store eoi replay", 1'b1, 2);
    access(1'b1, 2, 12'h200);
    access(1'b0, 2, 12'h000);
    exp_rsp("R7 store set ignored", 2'b10);

    // R8 offset fold
    access(1'b0, 1, 12'h230);
    errata_en = 1'b1;
    access(1'b0, 1, 12'h010);
    exp_rsp("R8 folded eoi old", 2'b11);
    exp_note("R8 folded eoi replay", 1'b1, 1);
    errata_en = 1'b0;
    access(1'b0, 1, 12'h010);
    exp_rsp("R8 unfolded is read", 2'b10);
    access(1'b0, 1, 12'h000);
    exp_rsp("R8 state unchanged", 2'b10);

    // R6 level source
    access(1'b0, 5, 12'h200);
    lvl_in[5] = 1'b1;
    step();
    exp_note("R6 level rise notifies", 1'b1, 5);
    step();
    exp_note("R6 held level no repeat", 1'b0, 5);
    access(1'b0, 5, 12'h100);
    exp_rsp("R6 level eoi old", 2'b10);
    exp_note("R6 level still high replays", 1'b1, 5);
    lvl_in[5] = 1'b0;
    step();
    access(1'b0, 5, 12'h100);
    exp_note("R6 level low no replay", 1'b0, 5);
    pulse(5);
    access(1'b0, 5, 12'h000);
    exp_rsp("R6 level ignores trig_in", 2'b00);

    // R11 same-cycle request and trigger
    access(1'b0, 3, 12'h230);
    trig_in[3] = 1'b1;
    access(1'b0, 3, 12'h100);
    trig_in = '0;
    exp_rsp("R11 eoi with trigger old", 2'b11);
    exp_note("R11 eoi replay notify", 1'b1, 3);
    access(1'b0, 3, 12'h000);
    exp_rsp("R11 trigger after replay", 2'b11);
    trig_in[3] = 1'b1;
    access(1'b0, 3, 12'h200);
    trig_in = '0;
    exp_note("R11 set then trigger", 1'b1, 3);

    // R9 hold and priority under back-pressure
    access(1'b0, 3, 12'h200);
    access(1'b0, 1, 12'h200);
    notify_ready = 1'b0;
    pulse(3);
    exp_note("R9 first offer", 1'b1, 3);
    pulse(1);
    exp_note("R9 held despite lower index", 1'b1, 3);
    step();
    exp_note("R9 still held", 1'b1, 3);
    notify_ready = 1'b1;
    step();
    exp_note("R9 next lowest", 1'b1, 1);
    step();
    exp_note("R9 drained", 1'b0, 0);

    // R10 response back-pressure
    rsp_ready = 1'b0;
    access(1'b0, 0, 12'h000);
    exp_rsp("R10 response held", 2'b00);
    chk(req_ready === 1'b0, "R10 req_ready low", req_ready, 0);
    access(1'b0, 0, 12'h230);
    exp_rsp("R10 response stable", 2'b00);
    rsp_ready = 1'b1;
    step();
    access(1'b0, 0, 12'h000);
    exp_rsp("R10 stalled request dropped", 2'b00);
    step();

    // random phase checked against the model
    for (int c = 0; c < 3000; c++) begin
      logic [2:0] k;
      k = 3'($urandom_range(0, 7));
      req_valid    = ($urandom_range(0, 3) != 0);
      req_store    = ($urandom_range(0, 7) == 0);
      req_src      = SW'($urandom_range(0, N - 1));
      errata_en    = ($urandom_range(0, 7) == 0);
      rsp_ready    = ($urandom_range(0, 3) != 0);
      notify_ready = ($urandom_range(0, 4) > 1);
      case (k)
        3'd0: req_ofs = 12'h000;
        3'd1: req_ofs = 12'h100;
        3'd2: req_ofs = 12'h200;
        3'd3: req_ofs = 12'h210;
        3'd4: req_ofs = 12'h220;
        3'd5: req_ofs = 12'h230;
        3'd6: req_ofs = 12'h010;
        default: req_ofs = OW'($urandom_range(0, 4095));
      endcase
      for (int s = 0; s < N; s++) begin
        trig_in[s] = ($urandom_range(0, 15) == 0);
        if ($urandom_range(0, 7) == 0) lvl_in[s] = ~lvl_in[s];
      end
      step();
    end
    req_valid = 1'b0; trig_in = '0; rsp_ready = 1'b1; notify_ready = 1'b1;
    step();

    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule